// File: doc/BRIEF.md
# Link Low-Power Entry Sequencer

This block is the transmit-side controller of a router port that puts its outgoing link direction into a low-power state. A single request starts it. It then sends a stream of power-off ordered-set descriptors, one per clock, to the serializer. No acknowledge from the link partner is needed or awaited. Each descriptor carries the requested target-state trit and a hop index, which tells the retimers on the link which burst is meant for which of them. Serialization and encoding of the sets happen downstream.

When the last descriptor has gone out, the block turns the transmitter off and raises a one-cycle completion pulse. It then settles the TX direction into CL0s, CL1 or CL2. The choice depends on the requested target and on how the receive direction entered its own low-power state earlier. The block stays in that state until reset.

Top module: `lpe_seq`

## Requirements
- R1: During and directly after reset, `tx_en_o` is 1, `tx_state_o` is 00 (active), `desc_vld_o` is 0 and `done_o` is 0.
- R2: A request sampled high while idle with the transmitter on starts the sequence. `desc_vld_o` is high from the next cycle on, one descriptor per cycle. Every descriptor's `desc_tgt_o` equals the `tgt_i` captured with the request. Trit codes are 00 = 0t, 01 = 1t and 10 = 2t.
- R3: With `hops_i` = 0, exactly 126 descriptors are sent, all with index 0.
- R4: With `hops_i` = N > 0, exactly 126×N descriptors are sent. The index starts at 1 and rises by one after each group of 126, ending at N.
- R5: In the cycle after the last descriptor, `tx_en_o` is 0 and `desc_vld_o` is 0. Both stay there until reset.
- R6: The TX state becomes CL2 (`tx_state_o` = 11) when the captured target is 2t and, at the final cycle, `rx_lp_i` = 1 and `rx_opt2_i` = 1.
- R7: The TX state becomes CL1 (`tx_state_o` = 10) when the captured target is 1t and `rx_lp_i` = 1 at the final cycle.
- R8: In every other case the TX state becomes CL0s (`tx_state_o` = 01). This includes target 0t, the unused code 11, and target 2t with an RX entry that was not made with 2t.
- R9: CL1 and CL2 are never entered unless the RX direction is in CL0s. Without that, the TX direction stops in CL0s.
- R10: A request that arrives while a sequence is running, or after the transmitter is off, is ignored. Neither the count, the index, the target field nor the final state changes.
- R11: `done_o` is high for exactly one cycle, in the same cycle that `tx_en_o` first reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Low-power entry request |
| tgt_i | input | 2 | Requested target-state trit |
| hops_i | input | HOP_W | Number of retimers on the link |
| rx_lp_i | input | 1 | RX direction is in CL0s |
| rx_opt2_i | input | 1 | RX CL0s was entered with target 2t |
| desc_vld_o | output | 1 | Descriptor valid |
| desc_tgt_o | output | 2 | Descriptor target-state trit |
| desc_idx_o | output | HOP_W | Descriptor hop index |
| tx_en_o | output | 1 | Transmitter enable |
| tx_state_o | output | 2 | TX state: 00 CL0, 01 CL0s, 10 CL1, 11 CL2 |
| done_o | output | 1 | One-cycle shutdown pulse |

## Verification
The assertions assume that `rx_lp_i` and `rx_opt2_i` describe a settled receive-side condition. They do not check when the RX status changes. They also assume that each entry is preceded by a reset, because no exit path exists. The stimulus therefore resets before every case and holds the RX status constant through the sequence. It still fires requests with different target and hop values in the middle of a burst and after shutdown, to show that such requests change nothing.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

  typedef enum logic [1:0] {
    TX_CL0  = 2'b00,
    TX_CL0S = 2'b01,
    TX_CL1  = 2'b10,
    TX_CL2  = 2'b11
  } tx_st_e;

  localparam logic [1:0] TRIT_0 = 2'b00;
  localparam logic [1:0] TRIT_1 = 2'b01;
  localparam logic [1:0] TRIT_2 = 2'b10;

  // Resting TX state once the transmitter has been turned off.
  function automatic tx_st_e pick_state(logic [1:0] tgt, logic rx_lp, logic rx_opt2);
    if (tgt == TRIT_2 && rx_lp && rx_opt2) return TX_CL2;
    if (tgt == TRIT_1 && rx_lp)            return TX_CL1;
    return TX_CL0S;
  endfunction

endpackage

// File: rtl/lpe_burst_ctr.sv
module lpe_burst_ctr #(
  parameter int SETS_PER_HOP = 126,
  parameter int HOP_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [HOP_W-1:0] hops_i,
  output logic             run_o,
  output logic [HOP_W-1:0] idx_o,
  output logic [HOP_W-1:0] lim_o,
  output logic             last_o
);
  localparam int CNT_W = $clog2(SETS_PER_HOP);
  localparam logic [CNT_W-1:0] SET_MAX = CNT_W'(SETS_PER_HOP - 1);

  logic [CNT_W-1:0] set_q;
  logic [HOP_W-1:0] idx_q, lim_q;
  logic             run_q;
  logic             grp_end, hop_end;

  assign grp_end = (set_q == SET_MAX);
  assign hop_end = (idx_q == lim_q);
  assign last_o  = run_q & grp_end & hop_end;
  assign run_o   = run_q;
  assign idx_o   = idx_q;
  assign lim_o   = lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      set_q <= '0;
      idx_q <= '0;
      lim_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      set_q <= '0;
      idx_q <= (hops_i == '0) ? '0 : HOP_W'(1);
      lim_q <= hops_i;
    end else if (run_q) begin
      if (grp_end) begin
        set_q <= '0;
        if (hop_end) run_q <= 1'b0;
        else         idx_q <= idx_q + HOP_W'(1);
      end else begin
        set_q <= set_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lpe_tx_state.sv
module lpe_tx_state
  import lpe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       last_i,
  input  logic [1:0] tgt_i,
  input  logic       rx_lp_i,
  input  logic       rx_opt2_i,
  output logic       tx_en_o,
  output logic [1:0] state_o,
  output logic       done_o
);
  tx_st_e state_q;
  logic   en_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      state_q <= TX_CL0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_i;
      if (last_i) begin
        en_q    <= 1'b0;
        state_q <= pick_state(tgt_i, rx_lp_i, rx_opt2_i);
      end
    end
  end

  assign tx_en_o = en_q;
  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/lpe_seq.sv
module lpe_seq #(
  parameter int SETS_PER_HOP = 126,
  parameter int HOP_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [1:0]       tgt_i,
  input  logic [HOP_W-1:0] hops_i,
  input  logic             rx_lp_i,
  input  logic             rx_opt2_i,
  output logic             desc_vld_o,
  output logic [1:0]       desc_tgt_o,
  output logic [HOP_W-1:0] desc_idx_o,
  output logic             tx_en_o,
  output logic [1:0]       tx_state_o,
  output logic             done_o
);
  // Named internal events, brought out for the checker.
  logic             seq_run, seq_start, seq_last;
  logic [HOP_W-1:0] hop_idx, hop_lim;
  logic [1:0]       tgt_q;
  logic             tx_en;

  assign seq_start = req_i & ~seq_run & tx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tgt_q <= 2'b00;
    else if (seq_start) tgt_q <= tgt_i;
  end

  lpe_burst_ctr #(.SETS_PER_HOP(SETS_PER_HOP), .HOP_W(HOP_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start_i(seq_start), .hops_i(hops_i),
    .run_o(seq_run), .idx_o(hop_idx), .lim_o(hop_lim), .last_o(seq_last)
  );

  lpe_tx_state u_st (
    .clk(clk), .rst_n(rst_n), .last_i(seq_last), .tgt_i(tgt_q),
    .rx_lp_i(rx_lp_i), .rx_opt2_i(rx_opt2_i),
    .tx_en_o(tx_en), .state_o(tx_state_o), .done_o(done_o)
  );

  assign desc_vld_o = seq_run;
  assign desc_tgt_o = tgt_q;
  assign desc_idx_o = hop_idx;
  assign tx_en_o    = tx_en;
endmodule

// File: rtl/lpe_seq_chk.sv
module lpe_seq_chk #(
  parameter int SETS_PER_HOP = 126,
  parameter int HOP_W        = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             desc_vld_o,
  input logic [1:0]       desc_tgt_o,
  input logic [HOP_W-1:0] desc_idx_o,
  input logic             tx_en_o,
  input logic [1:0]       tx_state_o,
  input logic             done_o,
  input logic             rx_lp_i,
  input logic             seq_start,
  input logic [HOP_W-1:0] hop_lim
);
  // Length of the current run of equal indices, counting this cycle.
  logic             prev_vld;
  logic [HOP_W-1:0] prev_idx;
  int               grp_cnt, run_len;

  assign run_len = (prev_vld && desc_idx_o == prev_idx) ? grp_cnt + 1 : 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld <= 1'b0;
      prev_idx <= '0;
      grp_cnt  <= 0;
    end else begin
      prev_vld <= desc_vld_o;
      prev_idx <= desc_idx_o;
      grp_cnt  <= desc_vld_o ? run_len : 0;
    end
  end

  AST_VLD_NEEDS_TXEN: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld_o |-> tx_en_o && tx_state_o == 2'b00); // R5
  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> !desc_vld_o && tx_en_o); // R10
  AST_TGT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld_o && $past(desc_vld_o) |-> $stable(desc_tgt_o)); // R2
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld_o && hop_lim != '0 |-> desc_idx_o >= 1 && desc_idx_o <= hop_lim); // R4
  AST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld_o && hop_lim == '0 |-> desc_idx_o == '0); // R3
  AST_GROUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld_o |-> run_len <= SETS_PER_HOP); // R4
  AST_GROUP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    desc_vld_o && prev_vld && desc_idx_o != prev_idx |-> grp_cnt == SETS_PER_HOP && desc_idx_o == prev_idx + 1'b1); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_DONE_TXOFF: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !tx_en_o && !desc_vld_o && $past(tx_en_o)); // R11
  AST_TXOFF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_o |=> !tx_en_o && $stable(tx_state_o)); // R5
  AST_DEEP_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && tx_state_o[1] |-> $past(rx_lp_i)); // R9
endmodule

bind lpe_seq lpe_seq_chk #(.SETS_PER_HOP(SETS_PER_HOP), .HOP_W(HOP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_vld_o(desc_vld_o), .desc_tgt_o(desc_tgt_o),
  .desc_idx_o(desc_idx_o), .tx_en_o(tx_en_o), .tx_state_o(tx_state_o),
  .done_o(done_o), .rx_lp_i(rx_lp_i), .seq_start(seq_start), .hop_lim(hop_lim)
);

// File: tb/lpe_seq_tb.sv
module lpe_seq_tb;
  localparam int SETS  = 126;
  localparam int HOP_W = 3;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, rx_lp = 1'b0, rx_o2 = 1'b0;
  logic [1:0] tgt = 2'b00;
  logic [HOP_W-1:0] hops = '0;
  logic desc_vld, tx_en, done;
  logic [1:0] desc_tgt, tx_state;
  logic [HOP_W-1:0] desc_idx;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  lpe_seq #(.SETS_PER_HOP(SETS), .HOP_W(HOP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .tgt_i(tgt), .hops_i(hops),
    .rx_lp_i(rx_lp), .rx_opt2_i(rx_o2), .desc_vld_o(desc_vld),
    .desc_tgt_o(desc_tgt), .desc_idx_o(desc_idx), .tx_en_o(tx_en),
    .tx_state_o(tx_state), .done_o(done)
  );

  function automatic int ref_state(logic [1:0] t, bit lp, bit o2);
    if (t == 2'b10 && lp && o2) return 3;  // CL2
    if (t == 2'b01 && lp)       return 2;  // CL1
    return 1;                              // CL0s
  endfunction

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_run = 0, m_txen = 1, m_done = 0;
  int m_pos = 0, m_total = 0, m_hops = 0, m_state = 0;
  logic [1:0] m_tgt = 2'b00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_txen = 1; m_done = 0; m_pos = 0; m_state = 0;
    end else begin
      m_done = 0;
      if (m_run) begin
        m_pos++;
        if (m_pos == m_total) begin
          m_run = 0; m_txen = 0; m_done = 1;
          m_state = ref_state(m_tgt, rx_lp, rx_o2);
        end
      end else if (req && m_txen) begin
        m_run = 1; m_pos = 0; m_hops = int'(hops); m_tgt = tgt;
        m_total = SETS * ((hops == 0) ? 1 : int'(hops));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R10 desc_vld", desc_vld, m_run);
      chk("R5 tx_en", tx_en, m_txen);
      chk("R6/R7/R8 tx_state", tx_state, m_state);
      chk("R11 done", done, m_done);
      if (m_run) begin
        chk("R2 desc_tgt", desc_tgt, m_tgt);
        if (m_hops == 0) chk("R3 desc_idx", desc_idx, 0);
        else             chk("R4 desc_idx", desc_idx, 1 + m_pos / SETS);
      end
    end
  end

  task automatic run_case(int h, logic [1:0] t, bit lp, bit o2, bit poke, string tag);
    int len;
    req = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    // R1: reset values
    chk("R1 tx_en", tx_en, 1);
    chk("R1 tx_state", tx_state, 0);
    chk("R1 desc_vld", desc_vld, 0);
    chk("R1 done", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    hops = HOP_W'(h); tgt = t; rx_lp = lp; rx_o2 = o2;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    len = SETS * ((h == 0) ? 1 : h);
    for (int i = 0; i < len + 4; i++) begin
      @(negedge clk);
      if (poke && (i == 40 || i == len + 1)) begin
        // R10: requests mid-burst and after shutdown must be ignored
        req = 1'b1; tgt = ~t; hops = HOP_W'(h + 1);
      end else begin
        req = 1'b0;
      end
    end
    req = 1'b0;
    @(negedge clk);
    chk({tag, " final tx_state"}, tx_state, ref_state(t, lp, o2));
    chk("R5 tx_en off at end", tx_en, 0);
  endtask

  initial begin
    run_case(0, 2'b01, 1, 0, 0, "R3/R7");  // no retimers, CL1
    run_case(2, 2'b10, 1, 1, 1, "R6/R10"); // CL2, pokes ignored
    run_case(3, 2'b10, 1, 0, 0, "R8");     // RX entered with 1t -> CL0s
    run_case(1, 2'b10, 0, 1, 0, "R9");     // RX not in CL0s -> CL0s
    run_case(1, 2'b01, 0, 0, 0, "R9");     // 1t without RX CL0s -> CL0s
    run_case(4, 2'b00, 1, 1, 1, "R8/R10"); // target 0t -> CL0s
    run_case(2, 2'b11, 1, 1, 0, "R8");     // unused code -> CL0s
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule